// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Triggers

This block is a memory-mapped general-purpose I/O controller for up to 32 pins. It is reached over a plain 32-bit register bus made of a byte address, a write strobe, write data and combinational read data. Software picks each pin's direction, sets the value driven on output pins, and reads back the live pin state. Input pins pass through a two-flop synchroniser before any other logic sees them.

Each pin can also raise an interrupt. Three per-pin registers set the trigger: an edge-or-level select, a polarity, and a both-edges select. Events are latched in a raw status register. A write-one-to-clear register acknowledges them. The pending view is the status masked by a per-pin enable, and a single interrupt line is the OR of all pending bits. A constant version word tells software that the both-edges select is present.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, every pin is an input (pin_oe all 0), and the output value, interrupt enable, status, edge select and both-edges registers are 0. The polarity register is all ones, and irq_o is 0.
- R2: Word address 0x04 holds the direction. A bit of 1 makes that pin an input and a bit of 0 makes it an output: pin_oe[i] is the inverse of direction bit i, and pin_out shows the value register at 0x00.
- R3: Reading 0x00 returns, for an input pin, pin_in after the two-flop synchroniser, and for an output pin the value written. Bits at and above NPINS read 0.
- R4: When bit i of the edge select (0x18) is 0, the pin is level-triggered, with polarity (0x1C) bit 1 for high and 0 for low. While that level holds, status bit i is set again on every cycle, so a clear has no lasting effect.
- R5: When the edge-select bit is 1 and the both-edges bit is 0, polarity 1 triggers on a rising edge and 0 on a falling edge. The status bit (0x0C) is set on the third rising clock after pin_in changes, and it stays set until it is cleared.
- R6: When the edge-select bit and the both-edges bit (0x24) are both 1, every transition of the pin sets its status bit, whatever its polarity bit is.
- R7: Writing 1 to bit i of 0x14 clears status bit i, and writing 0 leaves it unchanged. If a clear and a new event for the same pin fall in the same cycle, the bit ends up set.
- R8: Reading 0x10 returns status AND enable (0x08). irq_o is 1 exactly when that value is nonzero, so writing 0 to the enable masks every pin.
- R9: Address 0x20 reads the VERSION parameter, which is at least 3. NPINS lies between 1 and 32, and both are checked at elaboration.
- R10: Writes to the status, pending and version addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] are ignored |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | NPINS | Pin input levels |
| pin_out | output | NPINS | Output value register |
| pin_oe | output | NPINS | Output enable per pin (1 = drive) |
| irq_o | output | 1 | Combined interrupt |

## Verification
An acknowledge write and a freshly detected event on the same pin can land on the same clock edge. The bench provokes this by changing a pin configured for rising-edge triggering and timing the clear write to hit the edge on which the synchronised rise is first seen. The status bit must then read back set. The same write issued one cycle later must leave the bit clear. A level-triggered pin whose level persists is the second instance of this pairing, and each clear is judged by reading status three cycles afterwards.

// File: rtl/pic_pkg.sv
package pic_pkg;
   // word index (byte offset >> 2) of each register
   localparam int unsigned RW_VALUE = 0;
   localparam int unsigned RW_DIR   = 1;
   localparam int unsigned RW_IEN   = 2;
   localparam int unsigned RW_STAT  = 3;
   localparam int unsigned RW_PEND  = 4;
   localparam int unsigned RW_CLR   = 5;
   localparam int unsigned RW_EDGE  = 6;
   localparam int unsigned RW_POL   = 7;
   localparam int unsigned RW_VER   = 8;
   localparam int unsigned RW_BOTH  = 9;
   localparam int unsigned BUS_W    = 32;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   output logic [W-1:0] cur,
   output logic [W-1:0] prev
);
   logic [W-1:0] meta_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         meta_q <= '0;
         cur    <= '0;
         prev   <= '0;
      end else begin
         meta_q <= raw;
         cur    <= meta_q;
         prev   <= cur;
      end
   end
endmodule

// File: rtl/pic_trigger.sv
module pic_trigger #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   input  logic [W-1:0] prev,
   input  logic [W-1:0] edge_sel,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] both,
   output logic [W-1:0] evt
);
   for (genvar g = 0; g < W; g++) begin : g_pin
      logic lvl_hit, rise, fall;
      assign lvl_hit = pol[g] ? cur[g] : ~cur[g];
      assign rise    = cur[g] & ~prev[g];
      assign fall    = ~cur[g] & prev[g];
      assign evt[g]  = !edge_sel[g] ? lvl_hit :
                       both[g]      ? (rise | fall) :
                       pol[g]       ? rise : fall;
   end

   // R4
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((~edge_sel & ~(cur ^ pol) & ~evt) == '0));
   // R6
   both_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((edge_sel & both & (cur ^ prev) & ~evt) == '0));
   // R5
   edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((edge_sel & ~(cur ^ prev) & evt) == '0));
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
   import pic_pkg::*;
#(
   parameter int unsigned NPINS   = 8,
   parameter int unsigned VERSION = 3,
   parameter int unsigned ADDR_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq_o
);
   localparam int unsigned WIDX_W = ADDR_W - 2;

   // R9
   if (NPINS < 1 || NPINS > BUS_W) begin : g_bad_pins
      $error("pin_irq_ctrl: NPINS must be 1..32");
   end
   if (VERSION < 3) begin : g_bad_ver
      $error("pin_irq_ctrl: VERSION must be at least 3");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("pin_irq_ctrl: ADDR_W must be at least 6");
   end

   logic [WIDX_W-1:0] widx;
   logic [NPINS-1:0]  wpins;
   logic [NPINS-1:0]  val_q, dir_q, ien_q, stat_q, edge_q, pol_q, both_q;
   logic [NPINS-1:0]  s_cur, s_prev, evt, clr_mask, pend;
   logic              wr_clr;

   assign widx   = bus_addr[ADDR_W-1:2];
   assign wpins  = bus_wdata[NPINS-1:0];
   assign wr_clr = bus_we && (widx == WIDX_W'(RW_CLR));

   pic_sync #(.W(NPINS)) i_sync (
      .clk(clk), .rst_n(rst_n), .raw(pin_in), .cur(s_cur), .prev(s_prev)
   );

   pic_trigger #(.W(NPINS)) i_trig (
      .clk(clk), .rst_n(rst_n), .cur(s_cur), .prev(s_prev),
      .edge_sel(edge_q), .pol(pol_q), .both(both_q), .evt(evt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q  <= '0;
         dir_q  <= '1;
         ien_q  <= '0;
         edge_q <= '0;
         pol_q  <= '1;
         both_q <= '0;
      end else if (bus_we) begin
         case (widx)
            WIDX_W'(RW_VALUE): val_q  <= wpins;
            WIDX_W'(RW_DIR):   dir_q  <= wpins;
            WIDX_W'(RW_IEN):   ien_q  <= wpins;
            WIDX_W'(RW_EDGE):  edge_q <= wpins;
            WIDX_W'(RW_POL):   pol_q  <= wpins;
            WIDX_W'(RW_BOTH):  both_q <= wpins;
            default: ;
         endcase
      end
   end

   assign clr_mask = wr_clr ? wpins : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_mask) | evt;
   end

   assign pend    = stat_q & ien_q;
   assign irq_o   = |pend;
   assign pin_out = val_q;
   assign pin_oe  = ~dir_q;

   always_comb begin
      bus_rdata = '0;
      case (widx)
         WIDX_W'(RW_VALUE): bus_rdata = BUS_W'((val_q & ~dir_q) | (s_cur & dir_q));
         WIDX_W'(RW_DIR):   bus_rdata = BUS_W'(dir_q);
         WIDX_W'(RW_IEN):   bus_rdata = BUS_W'(ien_q);
         WIDX_W'(RW_STAT):  bus_rdata = BUS_W'(stat_q);
         WIDX_W'(RW_PEND):  bus_rdata = BUS_W'(pend);
         WIDX_W'(RW_EDGE):  bus_rdata = BUS_W'(edge_q);
         WIDX_W'(RW_POL):   bus_rdata = BUS_W'(pol_q);
         WIDX_W'(RW_VER):   bus_rdata = BUS_W'(VERSION);
         WIDX_W'(RW_BOTH):  bus_rdata = BUS_W'(both_q);
         default:           bus_rdata = '0;
      endcase
   end

   // R7
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && ((wpins & evt) == '0)) |=> ((stat_q & $past(wpins)) == '0));
   // R5
   event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));
   // R8
   mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq_o);
   // R10
   stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (widx == WIDX_W'(RW_STAT)) && (evt == '0)) |=> $stable(stat_q));
endmodule

// File: tb/test_pin_irq_ctrl.sv
module test_pin_irq_ctrl;
   localparam int N = 8;
   localparam logic [5:0] A_VAL = 6'h00, A_DIR = 6'h04, A_IEN = 6'h08,
      A_STAT = 6'h0C, A_PEND = 6'h10, A_CLR = 6'h14, A_EDGE = 6'h18,
      A_POL = 6'h1C, A_VER = 6'h20, A_BOTH = 6'h24;
   localparam int M_LVH = 0, M_LVL = 1, M_RISE = 2, M_FALL = 3, M_BOTH = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [5:0]    bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  pin_in = '0;
   logic [N-1:0]  pin_out, pin_oe;
   logic          irq_o;
   int            checks = 0;
   int            fails = 0;

   always #2 clk = ~clk;

   pin_irq_ctrl #(.NPINS(N), .VERSION(3), .ADDR_W(6)) i_pin_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic chk_irq(input string req, input logic [31:0] st, input logic [31:0] en);
      logic [31:0] d;
      rd(A_STAT, d); chk(req, d, st);
      rd(A_PEND, d); chk({req, " R8 pend"}, d, st & en);
      chk({req, " R8 irq"}, {31'd0, irq_o}, {31'd0, |(st & en)});
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      rd(A_DIR, d);  chk("R1 dir", d, 32'hFF);
      rd(A_IEN, d);  chk("R1 ien", d, 0);
      rd(A_STAT, d); chk("R1 stat", d, 0);
      rd(A_POL, d);  chk("R1 pol", d, 32'hFF);
      rd(A_EDGE, d); chk("R1 edge", d, 0);
      rd(A_BOTH, d); chk("R1 both", d, 0);
      chk("R1 oe", 32'(pin_oe), 0);
      chk("R1 out", 32'(pin_out), 0);
      chk("R1 irq", {31'd0, irq_o}, 0);
      // R9 version
      rd(A_VER, d); chk("R9 version", d, 3);

      // R2 / R3 direction and value
      wr(A_DIR, 32'hFFFF_FF0F);
      wr(A_VAL, 32'h0000_00A5);
      chk("R2 oe", 32'(pin_oe), 32'hF0);
      chk("R2 out", 32'(pin_out), 32'hA5);
      pin_in = 8'h3C;
      cyc(1);
      rd(A_VAL, d); chk("R3 sync not yet", d, (32'hA5 & 32'hF0) | (32'h00 & 32'h0F));
      cyc(1);
      rd(A_VAL, d); chk("R3 value mix", d, (32'hA5 & 32'hF0) | (32'h3C & 32'h0F));
      rd(A_DIR, d); chk("R3 upper bits zero", d, 32'h0F);
      wr(A_DIR, 32'hFF);
      pin_in = '0;
      cyc(3);
      wr(A_CLR, 32'hFF);
      cyc(1);

      // R4 R5 R6 R7 R8: sweep every pin through every trigger mode
      for (int i = 0; i < N; i++) begin
         for (int m = 0; m < 5; m++) begin
            logic [31:0] b, en, e_a, e_b, e_c, e_d, e_e;
            b  = 32'd1 << i;
            en = i[0] ? b : 32'd0;
            wr(A_EDGE, (m >= M_RISE) ? b : 32'd0);
            wr(A_POL,  (m == M_LVL || m == M_FALL) ? (32'hFF & ~b) : 32'hFF);
            wr(A_BOTH, (m == M_BOTH) ? b : 32'd0);
            wr(A_IEN, en);
            cyc(3);
            wr(A_CLR, 32'hFF);
            cyc(3);
            e_a = (m == M_LVL) ? b : 0;
            e_b = (m != M_FALL) ? b : 0;
            e_c = (m == M_LVH) ? b : 0;
            e_d = (m != M_RISE) ? b : 0;
            e_e = (m == M_LVL) ? b : 0;
            chk_irq("R4 low steady", e_a, en);
            pin_in[i] = 1'b1;
            cyc(3);
            chk_irq("R5 R6 rise", e_b, en);
            wr(A_CLR, 32'hFF);
            cyc(3);
            chk_irq("R4 R7 clear high", e_c, en);
            pin_in[i] = 1'b0;
            cyc(3);
            chk_irq("R5 R6 fall", e_d, en);
            wr(A_CLR, 32'hFF);
            cyc(3);
            chk_irq("R4 R7 clear low", e_e, en);
         end
      end

      // R7: clear and rising event in the same cycle, pin 0 rising edge
      wr(A_EDGE, 32'h01); wr(A_POL, 32'hFF); wr(A_BOTH, 0); wr(A_IEN, 32'hFF);
      cyc(2);
      wr(A_CLR, 32'hFF);
      cyc(1);
      pin_in[0] = 1'b1;
      cyc(2);
      wr(A_CLR, 32'h01);           // lands on the detecting edge
      rd(A_STAT, d); chk("R7 event wins", d, 32'h01);
      // R7: writing zeros leaves it set
      wr(A_CLR, 32'h00);
      rd(A_STAT, d); chk("R7 zero no effect", d, 32'h01);
      // R10: writes to read-only registers
      wr(A_STAT, 32'h00); wr(A_PEND, 32'h00); wr(A_VER, 32'h00);
      rd(A_STAT, d); chk("R10 stat kept", d, 32'h01);
      rd(A_VER, d);  chk("R10 version kept", d, 3);
      chk("R8 irq on", {31'd0, irq_o}, 1);
      // R8: mask all
      wr(A_IEN, 0);
      chk("R8 masked irq", {31'd0, irq_o}, 0);
      rd(A_PEND, d); chk("R8 masked pend", d, 0);
      // R7: clear one cycle after the event takes effect
      pin_in[0] = 1'b0;
      cyc(3);
      pin_in[0] = 1'b1;
      cyc(3);
      wr(A_CLR, 32'h01);
      rd(A_STAT, d); chk("R7 late clear", d, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule